// File: doc/BRIEF.md
# Coprocessor Deferred Exception Response Sequencer

This block sits in the host interface of a floating-point coprocessor and decides which primitive the host sees when it reads the response register. It watches the arithmetic unit, the conversion stage and the operand-store path. It never signals an exception on its own. Every exception is held and shown only as a response-register value at defined points in the host dialog.

An arithmetic exception that arrives while an instruction is still computing is latched in a single pending slot. It comes out as a take pre-instruction exception on the next command or condition write, in place of that new instruction's first dialog primitive. A conversion error during a store is reported as a take mid-instruction exception once the operand transfer finishes. A new instruction that finds the arithmetic unit busy gets a null primitive with its come-again and interrupt-allowed flags set. That null stays in place until the instruction can be handed off. If the unit raises an exception during that wait, the waiting instruction reports it as a mid-instruction exception.

The response word is 16 bits wide with the default 8-bit vector. Bits [15:11] hold the kind: null 00001, dialog 00010, pre-instruction 11100, mid-instruction 11101. Bit 10 is come-again, bit 9 is interrupt-allowed, bit 8 is zero, and bits [7:0] hold the exception vector. This gives idle null 0x0800, wait null 0x0E00, dialog 0x1000, pre-instruction 0xE000|vec and mid-instruction 0xE800|vec.

Top module: `cprs_resp_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to its idle state. After that edge `resp_o` reads 0x0800, `ovf_o` is 0 and `handoff_o` is 0.
- R2: An arithmetic exception (`apu_exc_i`) while the sequencer is idle is latched and not reported. `resp_o` keeps its value.
- R3: A command write (`cmd_wr_i`) with an exception pending makes `resp_o` read 0xE000 plus the pending vector after the next edge. No handoff happens.
- R4: A command write with nothing pending and `apu_busy_i` low gives `resp_o` = 0x1000 after the next edge. `handoff_o` is high for exactly that one cycle.
- R5: A non-store command write while `apu_busy_i` is high gives `resp_o` = 0x0E00. This holds while busy stays high. The edge after busy falls gives 0x1000 with a one-cycle `handoff_o`.
- R6: A store command write (`cmd_is_store_i` high) gives 0x1000. At the `store_done_i` edge, `resp_o` becomes 0x0800 if no conversion error occurred. If a conversion error (`cvt_err_i`) occurred during the transfer, it becomes 0xE800 plus the conversion vector, and before that edge it stays 0x1000.
- R7: An arithmetic exception that arrives while a new instruction waits on the wait null gives `resp_o` = 0xE800 plus that vector after the next edge.
- R8: Reading (`resp_rd_i`) while an exception primitive is shown clears the pending slot and returns `resp_o` to 0x0800. The next command write then gets 0x1000.
- R9: An exception arriving in the same cycle as the clearing read takes the freed slot without setting `ovf_o`. The next command write reports it as pre-instruction.
- R10: An exception that arrives while the slot is occupied is dropped, and the first vector is kept. `ovf_o` goes high and stays high until reset. Simultaneous arithmetic and conversion exceptions keep the arithmetic one and also set `ovf_o`.
- R11: A command write while an exception primitive is shown has no effect. `resp_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr_i | input | 1 | Host write to the command or condition register |
| cmd_is_store_i | input | 1 | The written instruction stores an operand to memory |
| resp_rd_i | input | 1 | Host read of the response register |
| apu_busy_i | input | 1 | Arithmetic unit cannot accept a handoff |
| apu_exc_i | input | 1 | Arithmetic unit raises an exception (one-cycle pulse) |
| apu_vec_i | input | 8 | Vector of the arithmetic exception |
| cvt_err_i | input | 1 | Conversion error on the operand store (pulse) |
| cvt_vec_i | input | 8 | Vector of the conversion error |
| store_done_i | input | 1 | Operand transfer to memory has completed (pulse) |
| resp_o | output | 16 | Response register primitive |
| handoff_o | output | 1 | Instruction handed to the arithmetic unit (one-cycle pulse) |
| ovf_o | output | 1 | Sticky flag: an exception was dropped |

## Verification
The bench targets the point where a latched exception has to displace the next dialog primitive. A design that reported the exception at once, or started the new instruction anyway, would show a pre-instruction code too early or a dialog word with a handoff pulse. It hits the clearing read in the same cycle as a fresh exception. A design that cleared last would lose the new exception, and one that checked occupancy before the clear would wrongly raise the overflow flag. It also raises an exception while the wait null is held, which must turn into a mid-instruction report rather than a stuck null or a handoff. Finally, it puts a conversion error ahead of the store completion, which must hold off until the transfer ends rather than appearing immediately.

// File: rtl/cprs_pkg.sv
// Shared types for the deferred exception response sequencer.
// Assumes the response word layout {kind[4:0], CA, IA, 1'b0, vector}.
package cprs_pkg;

    // Kind field of a response primitive (bits [15:11] of the word)
    typedef enum logic [4:0] {
        K_NULL = 5'b00001,
        K_GO   = 5'b00010,
        K_PRE  = 5'b11100,
        K_MID  = 5'b11101
    } prim_kind_e;

    // Sequencer phase
    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_XFER,
        S_EXC
    } seq_state_e;

    // Origin of the exception held in the pending slot
    typedef enum logic {
        SRC_ARITH = 1'b0,
        SRC_CONV  = 1'b1
    } exc_src_e;

endpackage

// File: rtl/cprs_exc_slot.sv
// Single-entry pending exception store.
// Holds one exception (vector plus origin) until cleared. A new exception
// in the same cycle as the clear wins the freed slot. An exception that
// finds the slot occupied is dropped and raises a sticky overflow flag.
// Arithmetic exceptions take precedence over simultaneous conversion errors.
module cprs_exc_slot #(
    parameter int VEC_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  arith_v_i,
    input  logic [VEC_W-1:0]      arith_vec_i,
    input  logic                  conv_v_i,
    input  logic [VEC_W-1:0]      conv_vec_i,
    input  logic                  clear_i,
    output logic                  pend_o,
    output logic [VEC_W-1:0]      vec_o,
    output cprs_pkg::exc_src_e    src_o,
    output logic                  ovf_o
);
    import cprs_pkg::*;

    logic any_v;
    logic slot_free;
    logic both_v;

    // Decide whether an arriving exception can be stored
    always_comb begin
        any_v     = arith_v_i | conv_v_i;
        slot_free = !pend_o || clear_i;
        both_v    = arith_v_i & conv_v_i;
    end

    // Slot contents: fill on a free slot, otherwise honour a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
            vec_o  <= '0;
            src_o  <= SRC_ARITH;
        end else if (any_v && slot_free) begin
            pend_o <= 1'b1;
            vec_o  <= arith_v_i ? arith_vec_i : conv_vec_i;
            src_o  <= arith_v_i ? SRC_ARITH : SRC_CONV;
        end else if (clear_i) begin
            pend_o <= 1'b0;
        end
    end

    // Sticky overflow on any dropped exception
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_o <= 1'b0;
        end else if ((any_v && !slot_free) || both_v) begin
            ovf_o <= 1'b1;
        end
    end

endmodule

// File: rtl/cprs_resp_pack.sv
// Response register. Packs kind, flags and vector into one word when loaded
// and holds it otherwise. Reset leaves the idle null primitive.
module cprs_resp_pack #(
    parameter int VEC_W = 8,
    localparam int RESP_W = VEC_W + 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  cprs_pkg::prim_kind_e    kind_i,
    input  logic                    again_i,
    input  logic [VEC_W-1:0]        vec_i,
    output logic [RESP_W-1:0]       word_o
);
    import cprs_pkg::*;

    // Register the primitive seen by the host
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= {K_NULL, 3'b000, {VEC_W{1'b0}}};
        end else if (load_i) begin
            word_o <= {kind_i, again_i, again_i, 1'b0, vec_i};
        end
    end

endmodule

// File: rtl/cprs_seq_fsm.sv
// Protocol sequencer. Picks the next response primitive at each protocol
// point: command write, wait for the arithmetic unit, end of a store, and
// the host read of an exception primitive. Assumes the host issues no new
// command while an exception primitive is outstanding (such writes are ignored).
module cprs_seq_fsm #(
    parameter int VEC_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_wr_i,
    input  logic                  cmd_is_store_i,
    input  logic                  resp_rd_i,
    input  logic                  apu_busy_i,
    input  logic                  apu_exc_i,
    input  logic [VEC_W-1:0]      apu_vec_i,
    input  logic                  cvt_err_i,
    input  logic [VEC_W-1:0]      cvt_vec_i,
    input  logic                  store_done_i,
    input  logic                  pend_i,
    input  logic [VEC_W-1:0]      pend_vec_i,
    input  cprs_pkg::exc_src_e    pend_src_i,
    output logic                  load_o,
    output cprs_pkg::prim_kind_e  kind_o,
    output logic                  again_o,
    output logic [VEC_W-1:0]      vec_o,
    output logic                  clear_o,
    output logic                  handoff_o
);
    import cprs_pkg::*;

    seq_state_e state_q, state_d;
    logic       handoff_d;
    logic       conv_hit;

    // Next phase and the primitive to load
    always_comb begin
        state_d   = state_q;
        load_o    = 1'b0;
        kind_o    = K_NULL;
        again_o   = 1'b0;
        vec_o     = '0;
        clear_o   = 1'b0;
        handoff_d = 1'b0;
        conv_hit  = (pend_i && pend_src_i == SRC_CONV) ||
                    (cvt_err_i && !pend_i && !apu_exc_i);
        unique case (state_q)
            S_IDLE: begin
                if (cmd_wr_i) begin
                    load_o = 1'b1;
                    if (pend_i) begin
                        state_d = S_EXC;
                        kind_o  = K_PRE;
                        vec_o   = pend_vec_i;
                    end else if (cmd_is_store_i) begin
                        state_d = S_XFER;
                        kind_o  = K_GO;
                    end else if (apu_busy_i) begin
                        state_d = S_WAIT;
                        kind_o  = K_NULL;
                        again_o = 1'b1;
                    end else begin
                        kind_o    = K_GO;
                        handoff_d = 1'b1;
                    end
                end else if (resp_rd_i) begin
                    load_o = 1'b1;
                    kind_o = K_NULL;
                end
            end
            S_WAIT: begin
                if (pend_i || apu_exc_i) begin
                    state_d = S_EXC;
                    load_o  = 1'b1;
                    kind_o  = K_MID;
                    vec_o   = pend_i ? pend_vec_i : apu_vec_i;
                end else if (!apu_busy_i) begin
                    state_d   = S_IDLE;
                    load_o    = 1'b1;
                    kind_o    = K_GO;
                    handoff_d = 1'b1;
                end
            end
            S_XFER: begin
                if (store_done_i) begin
                    load_o = 1'b1;
                    if (conv_hit) begin
                        state_d = S_EXC;
                        kind_o  = K_MID;
                        vec_o   = pend_i ? pend_vec_i : cvt_vec_i;
                    end else begin
                        state_d = S_IDLE;
                        kind_o  = K_NULL;
                    end
                end
            end
            S_EXC: begin
                if (resp_rd_i) begin
                    state_d = S_IDLE;
                    load_o  = 1'b1;
                    kind_o  = K_NULL;
                    clear_o = 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Phase register and registered handoff pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            handoff_o <= 1'b0;
        end else begin
            state_q   <= state_d;
            handoff_o <= handoff_d;
        end
    end

endmodule

// File: rtl/cprs_resp_seq.sv
// Top of the deferred exception response sequencer. Joins the pending slot,
// the protocol sequencer and the response register. All exception reports
// leave through resp_o; nothing is signalled asynchronously.
module cprs_resp_seq #(
    parameter int VEC_W = 8,
    localparam int RESP_W = VEC_W + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_i,
    input  logic              cmd_is_store_i,
    input  logic              resp_rd_i,
    input  logic              apu_busy_i,
    input  logic              apu_exc_i,
    input  logic [VEC_W-1:0]  apu_vec_i,
    input  logic              cvt_err_i,
    input  logic [VEC_W-1:0]  cvt_vec_i,
    input  logic              store_done_i,
    output logic [RESP_W-1:0] resp_o,
    output logic              handoff_o,
    output logic              ovf_o
);
    import cprs_pkg::*;

    logic             pend;
    logic [VEC_W-1:0] pend_vec;
    exc_src_e         pend_src;
    logic             clear;
    logic             load;
    prim_kind_e       kind;
    logic             again;
    logic [VEC_W-1:0] vec;

    cprs_exc_slot #(.VEC_W(VEC_W)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .arith_v_i   (apu_exc_i),
        .arith_vec_i (apu_vec_i),
        .conv_v_i    (cvt_err_i),
        .conv_vec_i  (cvt_vec_i),
        .clear_i     (clear),
        .pend_o      (pend),
        .vec_o       (pend_vec),
        .src_o       (pend_src),
        .ovf_o       (ovf_o)
    );

    cprs_seq_fsm #(.VEC_W(VEC_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_wr_i       (cmd_wr_i),
        .cmd_is_store_i (cmd_is_store_i),
        .resp_rd_i      (resp_rd_i),
        .apu_busy_i     (apu_busy_i),
        .apu_exc_i      (apu_exc_i),
        .apu_vec_i      (apu_vec_i),
        .cvt_err_i      (cvt_err_i),
        .cvt_vec_i      (cvt_vec_i),
        .store_done_i   (store_done_i),
        .pend_i         (pend),
        .pend_vec_i     (pend_vec),
        .pend_src_i     (pend_src),
        .load_o         (load),
        .kind_o         (kind),
        .again_o        (again),
        .vec_o          (vec),
        .clear_o        (clear),
        .handoff_o      (handoff_o)
    );

    cprs_resp_pack #(.VEC_W(VEC_W)) u_resp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .kind_i  (kind),
        .again_i (again),
        .vec_i   (vec),
        .word_o  (resp_o)
    );

endmodule

// File: rtl/cprs_resp_seq_chk.sv
// Protocol checker for the response sequencer, bound to the top module.
// Observes ports only; the kind field is resp_o[RESP_W-1:RESP_W-5].
module cprs_resp_seq_chk #(
    parameter int VEC_W = 8,
    localparam int RESP_W = VEC_W + 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wr_i,
    input logic              resp_rd_i,
    input logic              apu_busy_i,
    input logic              apu_exc_i,
    input logic              store_done_i,
    input logic [RESP_W-1:0] resp_o,
    input logic              handoff_o,
    input logic              ovf_o
);
    localparam logic [RESP_W-1:0] IDLE_W = {5'b00001, 3'b000, {VEC_W{1'b0}}};
    localparam logic [RESP_W-1:0] WAIT_W = {5'b00001, 3'b110, {VEC_W{1'b0}}};

    logic [4:0] kind;
    assign kind = resp_o[RESP_W-1:RESP_W-5];

    // R1: reset leaves the idle null primitive
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> resp_o == IDLE_W);

    // R3: a pre-instruction report only follows a command write
    assert_pre_after_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 5'b11100 && !$stable(resp_o)) |-> $past(cmd_wr_i));

    // R6 and R7: a mid-instruction report follows a store end or a held wait null
    assert_mid_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 5'b11101 && !$stable(resp_o)) |->
        ($past(store_done_i) || $past(resp_o) == WAIT_W));

    // R5: handoff only when the arithmetic unit was free
    assert_handoff_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        handoff_o |-> !$past(apu_busy_i));

    // R5: wait null is held while busy and no exception arrives
    assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_o == WAIT_W && apu_busy_i && !apu_exc_i) |=>
        (resp_o == WAIT_W || resp_o[RESP_W-1:RESP_W-5] == 5'b11101));

    // R10: overflow flag is sticky
    assert_no_overflow_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    // R8: reading an exception primitive returns the idle null
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_rd_i && (kind == 5'b11100 || kind == 5'b11101)) |=> resp_o == IDLE_W);

endmodule

bind cprs_resp_seq cprs_resp_seq_chk #(.VEC_W(VEC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr_i     (cmd_wr_i),
    .resp_rd_i    (resp_rd_i),
    .apu_busy_i   (apu_busy_i),
    .apu_exc_i    (apu_exc_i),
    .store_done_i (store_done_i),
    .resp_o       (resp_o),
    .handoff_o    (handoff_o),
    .ovf_o        (ovf_o)
);

// File: tb/cprs_resp_seq_test.sv
// Directed bench: one task per scenario, each checking its own results.
module cprs_resp_seq_test;
    localparam logic [15:0] W_IDLE = 16'h0800;
    localparam logic [15:0] W_WAIT = 16'h0E00;
    localparam logic [15:0] W_GO   = 16'h1000;
    localparam logic [15:0] W_PRE  = 16'hE000;
    localparam logic [15:0] W_MID  = 16'hE800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr_i = 1'b0, cmd_is_store_i = 1'b0, resp_rd_i = 1'b0;
    logic        apu_busy_i = 1'b0, apu_exc_i = 1'b0, cvt_err_i = 1'b0, store_done_i = 1'b0;
    logic [7:0]  apu_vec_i = '0, cvt_vec_i = '0;
    logic [15:0] resp_o;
    logic        handoff_o, ovf_o;
    int          checks = 0;
    int          failures = 0;

    always #2.5 clk = ~clk;

    cprs_resp_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr_i), .cmd_is_store_i(cmd_is_store_i),
        .resp_rd_i(resp_rd_i), .apu_busy_i(apu_busy_i), .apu_exc_i(apu_exc_i),
        .apu_vec_i(apu_vec_i), .cvt_err_i(cvt_err_i), .cvt_vec_i(cvt_vec_i),
        .store_done_i(store_done_i), .resp_o(resp_o), .handoff_o(handoff_o), .ovf_o(ovf_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock, then clear all pulses; outputs are read 1 ns after the edge
    task automatic step();
        @(posedge clk); #1;
        cmd_wr_i = 0; cmd_is_store_i = 0; resp_rd_i = 0;
        apu_exc_i = 0; cvt_err_i = 0; store_done_i = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; apu_busy_i = 0;
        step(); step();
        rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 resp", resp_o, W_IDLE);
        chk("R1 ovf", {15'd0, ovf_o}, 16'd0);
        chk("R1 handoff", {15'd0, handoff_o}, 16'd0);
    endtask

    task automatic t_plain();
        do_reset();
        cmd_wr_i = 1; step();
        chk("R4 dialog", resp_o, W_GO);
        chk("R4 handoff", {15'd0, handoff_o}, 16'd1);
        step();
        chk("R4 handoff one cycle", {15'd0, handoff_o}, 16'd0);
    endtask

    task automatic t_busy();
        do_reset();
        apu_busy_i = 1; cmd_wr_i = 1; step();
        chk("R5 wait null", resp_o, W_WAIT);
        step(); step();
        chk("R5 wait held", resp_o, W_WAIT);
        chk("R5 no handoff", {15'd0, handoff_o}, 16'd0);
        apu_busy_i = 0; step();
        chk("R5 dialog after busy", resp_o, W_GO);
        chk("R5 handoff", {15'd0, handoff_o}, 16'd1);
    endtask

    task automatic t_pre();
        do_reset();
        apu_exc_i = 1; apu_vec_i = 8'h35; step();
        chk("R2 latched silent", resp_o, W_IDLE);
        step();
        cmd_wr_i = 1; step();
        chk("R3 pre exception", resp_o, W_PRE | 16'h0035);
        chk("R3 no handoff", {15'd0, handoff_o}, 16'd0);
        cmd_wr_i = 1; step();
        chk("R11 cmd ignored", resp_o, W_PRE | 16'h0035);
        resp_rd_i = 1; step();
        chk("R8 read clears", resp_o, W_IDLE);
        cmd_wr_i = 1; step();
        chk("R8 next dialog", resp_o, W_GO);
    endtask

    task automatic t_store_ok();
        do_reset();
        cmd_wr_i = 1; cmd_is_store_i = 1; step();
        chk("R6 store dialog", resp_o, W_GO);
        step();
        store_done_i = 1; step();
        chk("R6 store clean", resp_o, W_IDLE);
    endtask

    task automatic t_store_err();
        do_reset();
        cmd_wr_i = 1; cmd_is_store_i = 1; step();
        cvt_err_i = 1; cvt_vec_i = 8'h07; step();
        chk("R6 not before transfer end", resp_o, W_GO);
        store_done_i = 1; step();
        chk("R6 mid exception", resp_o, W_MID | 16'h0007);
        resp_rd_i = 1; step();
        cmd_wr_i = 1; step();
        chk("R8 cleared after mid", resp_o, W_GO);
    endtask

    task automatic t_wait_mid();
        do_reset();
        apu_busy_i = 1; cmd_wr_i = 1; step();
        step();
        apu_exc_i = 1; apu_vec_i = 8'h52; step();
        chk("R7 mid from earlier", resp_o, W_MID | 16'h0052);
        chk("R7 no handoff", {15'd0, handoff_o}, 16'd0);
        apu_busy_i = 0; resp_rd_i = 1; step();
        chk("R8 idle after read", resp_o, W_IDLE);
    endtask

    task automatic t_race();
        do_reset();
        apu_exc_i = 1; apu_vec_i = 8'h40; step();
        cmd_wr_i = 1; step();
        resp_rd_i = 1; apu_exc_i = 1; apu_vec_i = 8'h41; step();
        chk("R9 idle after read", resp_o, W_IDLE);
        chk("R9 no overflow", {15'd0, ovf_o}, 16'd0);
        cmd_wr_i = 1; step();
        chk("R9 new exc kept", resp_o, W_PRE | 16'h0041);
    endtask

    task automatic t_overflow();
        do_reset();
        apu_exc_i = 1; apu_vec_i = 8'h11; step();
        chk("R10 no overflow yet", {15'd0, ovf_o}, 16'd0);
        apu_exc_i = 1; apu_vec_i = 8'h22; step();
        chk("R10 overflow set", {15'd0, ovf_o}, 16'd1);
        cmd_wr_i = 1; step();
        chk("R10 first kept", resp_o, W_PRE | 16'h0011);
        resp_rd_i = 1; step();
        chk("R10 overflow sticky", {15'd0, ovf_o}, 16'd1);
        do_reset();
        apu_exc_i = 1; apu_vec_i = 8'h61; cvt_err_i = 1; cvt_vec_i = 8'h62; step();
        chk("R10 both overflow", {15'd0, ovf_o}, 16'd1);
        cmd_wr_i = 1; step();
        chk("R10 arith wins", resp_o, W_PRE | 16'h0061);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_plain();
        t_busy();
        t_pre();
        t_store_ok();
        t_store_err();
        t_wait_mid();
        t_race();
        t_overflow();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule